// File: doc/BRIEF.md
# PCM Highway Timeslot Serial Port

This block moves one PCM sample per frame in each direction over a time-division serial highway. The highway has a bit clock and a frame sync. A rising frame sync that the bit clock samples starts a new frame and clears a bit counter. The counter then advances once per bit clock. The block drives the transmit data pin only while the counter is inside the transmit window. At all other times it drops the output enable so that the pad floats. The receive data pin is captured on the falling clock edge while the counter is inside a separate receive window.

Each window opens at its own programmable bit count. A window is 8 bits long for a narrow sample, or 16 bits for a linear sample that fills two adjacent timeslots with no gap between them. Data is serialised most significant bit first in both directions. The parallel transmit word, the two start counts and the width select are all captured at the frame start. A completed receive word appears with a single-cycle valid strobe.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is held and after its release, before any frame start, dtx_oe is 0, rx_valid is 0 and rx_sample is 0.
- R2: A frame starts at the first clock rise where fsync is 1 after having been 0. The bit count is 0 in the cycle that follows. A sync held high for several cycles starts exactly one frame.
- R3: dtx_oe is 1 exactly in the cycles whose bit count lies in [tx_start, tx_start+L), and 0 in all other cycles. L is 8 when wide_sel is 0 and 16 when wide_sel is 1.
- R4: In the cycle with count tx_start+i, dtx carries bit L-1-i of the latched transmit word (MSB first). A narrow sample uses tx_sample[7:0].
- R5: With wide_sel=1 the 16 bits go out and come in as one unbroken run covering two consecutive 8-bit timeslots.
- R6: drx is sampled on the falling clock edge inside each cycle whose count lies in [rx_start, rx_start+L), first bit as MSB. A narrow word appears zero-extended in rx_sample[7:0].
- R7: rx_valid is 1 for exactly one cycle, the cycle with count rx_start+L, and rx_sample holds the new word from that cycle on.
- R8: tx_sample, tx_start, rx_start and wide_sel are taken at the frame start only. Changing them later in the frame alters neither dtx, dtx_oe nor the received word.
- R9: drx values outside the receive window have no effect on rx_sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, short or long pulse |
| drx | input | 1 | Serial receive data |
| tx_sample | input | 16 | Parallel transmit word |
| tx_start | input | 10 | Transmit window start count |
| rx_start | input | 10 | Receive window start count |
| wide_sel | input | 1 | 1 selects 16-bit two-slot samples |
| dtx | output | 1 | Serial transmit data |
| dtx_oe | output | 1 | Pad output enable for dtx |
| rx_sample | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new word |

## Verification
The assertions assume a well-formed highway. Each window ends within the counter range, so start plus length stays below 1023. Frame syncs are spaced so that windows never wrap into the next frame, and the transmit window of one frame never touches the one of the next. Under these conditions, the enable runs no longer than one sample and each receive strobe stands alone. The bench keeps every frame longer than both windows plus one cycle. It drives every input two nanoseconds after the rising edge, so drx is stable at the falling edge. It also puts a varying pattern on drx outside the windows.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int CNT_W    = 10;
    localparam int SAMP_W   = 16;
    localparam int NARROW_W = 8;
    localparam int IDX_W    = $clog2(SAMP_W);

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SAMP_W-1:0] samp_t;

    typedef enum logic {
        SLOT_NARROW = 1'b0,
        SLOT_WIDE   = 1'b1
    } slot_mode_e;

    typedef struct packed {
        cnt_t       tx_start;
        cnt_t       rx_start;
        slot_mode_e mode;
    } port_cfg_t;

    function automatic logic [CNT_W:0] slot_len(slot_mode_e m);
        return (m == SLOT_WIDE) ? (CNT_W+1)'(SAMP_W) : (CNT_W+1)'(NARROW_W);
    endfunction

    function automatic logic in_window(cnt_t c, cnt_t s, slot_mode_e m);
        logic [CNT_W:0] ce;
        logic [CNT_W:0] se;
        ce = {1'b0, c};
        se = {1'b0, s};
        return (ce >= se) && (ce < se + slot_len(m));
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    output logic frame_start,
    output logic run,
    output cnt_t cnt
);
    localparam cnt_t CNT_MAX = '1;

    logic fsync_q;

    assign frame_start = fsync & ~fsync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsync_q <= 1'b0;
            cnt     <= '0;
            run     <= 1'b0;
        end else begin
            fsync_q <= fsync;
            if (frame_start) begin
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                if (cnt == CNT_MAX) run <= 1'b0;
                else                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
    import pcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       run,
    input  cnt_t       cnt,
    input  cnt_t       start,
    input  slot_mode_e mode,
    input  samp_t      sample_in,
    output logic       dtx,
    output logic       dtx_oe
);
    samp_t            tx_buf;
    cnt_t             offset;
    logic [IDX_W-1:0] bit_idx;

    always_ff @(posedge clk) begin
        if (rst)              tx_buf <= '0;
        else if (frame_start) tx_buf <= sample_in;
    end

    assign offset  = cnt - start;
    assign bit_idx = IDX_W'(slot_len(mode) - 1'b1) - offset[IDX_W-1:0];
    assign dtx_oe  = run & in_window(cnt, start, mode);
    assign dtx     = dtx_oe & tx_buf[bit_idx];
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
    import pcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       drx,
    input  logic       run,
    input  cnt_t       cnt,
    input  cnt_t       start,
    input  slot_mode_e mode,
    output samp_t      rx_sample,
    output logic       rx_valid
);
    logic  drx_n;
    samp_t rx_sh;
    samp_t next_sh;
    cnt_t  offset;
    logic  take;
    logic  last;

    always_ff @(negedge clk) begin
        if (rst) drx_n <= 1'b0;
        else     drx_n <= drx;
    end

    assign offset  = cnt - start;
    assign take    = run & in_window(cnt, start, mode);
    assign last    = take && ({1'b0, offset} == slot_len(mode) - 1'b1);
    assign next_sh = {rx_sh[SAMP_W-2:0], drx_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh     <= '0;
            rx_sample <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= last;
            if (take) rx_sh <= next_sh;
            if (last) begin
                if (mode == SLOT_WIDE) rx_sample <= next_sh;
                else rx_sample <= {{(SAMP_W-NARROW_W){1'b0}}, next_sh[NARROW_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fsync,
    input  logic        drx,
    input  logic [15:0] tx_sample,
    input  logic [9:0]  tx_start,
    input  logic [9:0]  rx_start,
    input  logic        wide_sel,
    output logic        dtx,
    output logic        dtx_oe,
    output logic [15:0] rx_sample,
    output logic        rx_valid
);
    logic      frame_start;
    logic      run;
    cnt_t      cnt;
    port_cfg_t cfg;

    pcm_frame_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .fsync       (fsync),
        .frame_start (frame_start),
        .run         (run),
        .cnt         (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.tx_start <= '0;
            cfg.rx_start <= '0;
            cfg.mode     <= SLOT_NARROW;
        end else if (frame_start) begin
            cfg.tx_start <= tx_start;
            cfg.rx_start <= rx_start;
            cfg.mode     <= wide_sel ? SLOT_WIDE : SLOT_NARROW;
        end
    end

    pcm_tx_slot u_tx (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .run         (run),
        .cnt         (cnt),
        .start       (cfg.tx_start),
        .mode        (cfg.mode),
        .sample_in   (tx_sample),
        .dtx         (dtx),
        .dtx_oe      (dtx_oe)
    );

    pcm_rx_slot u_rx (
        .clk       (clk),
        .rst       (rst),
        .drx       (drx),
        .run       (run),
        .cnt       (cnt),
        .start     (cfg.rx_start),
        .mode      (cfg.mode),
        .rx_sample (rx_sample),
        .rx_valid  (rx_valid)
    );
endmodule

// File: rtl/pcm_slot_chk.sv
module pcm_slot_chk
    import pcm_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      frame_start,
    input logic      run,
    input cnt_t      cnt,
    input port_cfg_t cfg,
    input logic      dtx_oe,
    input logic      rx_valid
);
    logic [CNT_W:0] oe_run;

    always_ff @(posedge clk) begin
        if (rst || !dtx_oe) oe_run <= '0;
        else                oe_run <= oe_run + 1'b1;
    end

    // R2
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cnt == '0) && run);

    // R3
    oe_opens_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dtx_oe) |-> (cnt == cfg.tx_start));

    // R5
    oe_run_length_chk: assert property (@(posedge clk) disable iff (rst)
        dtx_oe |-> (oe_run < slot_len(cfg.mode)));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind pcm_slot_port pcm_slot_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .run         (run),
    .cnt         (cnt),
    .cfg         (cfg),
    .dtx_oe      (dtx_oe),
    .rx_valid    (rx_valid)
);

// File: tb/tb_pcm_slot_port.sv
module tb_pcm_slot_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fsync = 1'b0;
    logic        drx = 1'b0;
    logic [15:0] tx_sample = '0;
    logic [9:0]  tx_start = '0;
    logic [9:0]  rx_start = '0;
    logic        wide_sel = 1'b0;
    logic        dtx;
    logic        dtx_oe;
    logic [15:0] rx_sample;
    logic        rx_valid;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    pcm_slot_port dut (
        .clk(clk), .rst(rst), .fsync(fsync), .drx(drx),
        .tx_sample(tx_sample), .tx_start(tx_start), .rx_start(rx_start),
        .wide_sel(wide_sel), .dtx(dtx), .dtx_oe(dtx_oe),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops expected received words as rx_valid strobes (R6, R7, R9)
    always @(posedge clk) begin
        #2;
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", 32'(rx_sample), 32'h0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                check(rx_sample == e, "R6 R9 rx word", 32'(rx_sample), 32'(e));
            end
        end
    end

    // Driver: one frame. Called 2 ns after a rising edge with fsync low.
    task automatic run_frame(input logic [15:0] txv, input logic [15:0] rxv,
                             input int txs, input int rxs, input bit wide,
                             input int flen, input int fsl, input bit scramble);
        int L;
        L = wide ? 16 : 8;
        tx_sample = txv;
        tx_start  = 10'(txs);
        rx_start  = 10'(rxs);
        wide_sel  = wide;
        fsync     = 1'b1;
        for (int k = 0; k < flen; k++) begin
            @(posedge clk);
            #2;
            if (k + 1 >= fsl) fsync = 1'b0;
            if (k == 0 && scramble) begin
                // R8: late changes must be ignored
                tx_sample = ~txv;
                tx_start  = 10'(txs + 3);
                rx_start  = 10'(rxs + 2);
                wide_sel  = ~wide;
            end
            if (k >= txs && k < txs + L) begin
                check(dtx_oe === 1'b1, "R3 R5 oe in window", 32'(dtx_oe), 32'h1);
                check(dtx === txv[L-1-(k-txs)], "R4 R8 dtx bit", 32'(dtx),
                      32'(txv[L-1-(k-txs)]));
            end else begin
                check(dtx_oe === 1'b0, "R3 R2 oe outside window", 32'(dtx_oe), 32'h0);
            end
            check(rx_valid === (k == rxs + L), "R7 strobe timing", 32'(rx_valid),
                  32'(k == rxs + L));
            if (k >= rxs && k < rxs + L) drx = rxv[L-1-(k-rxs)];
            else                         drx = k[0] ^ k[2];
            if (k == rxs + L - 1) begin
                if (wide) exp_q.push_back(rxv);
                else      exp_q.push_back({8'h00, rxv[7:0]});
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 during reset
        check(dtx_oe === 1'b0 && rx_valid === 1'b0 && rx_sample === 16'h0,
              "R1 reset state", {dtx_oe, rx_valid, 14'h0, rx_sample}, 32'h0);
        rst = 1'b0;
        repeat (4) begin
            @(posedge clk);
            #2;
            // R1 after release, no frame yet
            check(dtx_oe === 1'b0 && rx_valid === 1'b0, "R1 idle", {dtx_oe, rx_valid}, 32'h0);
        end
        run_frame(16'h00A5, 16'h003C, 0, 0, 1'b0, 40, 1, 1'b0);
        run_frame(16'hC3E1, 16'h9B27, 10, 3, 1'b1, 48, 5, 1'b0);
        run_frame(16'h1281, 16'h00F0, 20, 25, 1'b0, 50, 2, 1'b1);
        run_frame(16'h8001, 16'h7FFE, 5, 17, 1'b1, 40, 3, 1'b1);
        run_frame(16'h5A3C, 16'hE00F, 1000, 1000, 1'b1, 1100, 1, 1'b0);
        run_frame(16'hFFFF, 16'h0081, 8, 30, 1'b0, 45, 7, 1'b0);
        repeat (5) @(posedge clk);
        #2;
        check(exp_q.size() == 0, "R7 all words delivered", 32'(exp_q.size()), 32'h0);
        check(dtx_oe === 1'b0, "R3 idle after frames", 32'(dtx_oe), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule